// File: doc/BRIEF.md
# Shared-Master Latch Register File

A register file of R words of W bits. It is built from split latches, not edge-triggered flip-flops. Each bit of the write data bus enters exactly one master latch. The R slave latches that hold that bit position in every word all take their input from that one master. The bus therefore sees one latch load per bit instead of R.

Each word has a latch-based clock-gating cell driven by its write-enable bit. A word whose bit is low gets no slave clock pulse and keeps its value without any recirculating multiplexer. The master is clocked through a gating cell of the same form, whose enable is the OR of all word enables. Its gated clock therefore passes through the same single AND gate as every slave clock and never rises ahead of them.

One value is written per cycle, into any set of words chosen by a multi-hot enable vector. Two independent combinational read ports return stored words by binary address.

Top module: `srf_latch_regfile`

## Requirements
- R1: When bit i of `wen` is 1 (bit i selects word i) during the low phase before a rising edge of `clk`, word i holds the `wdata` value of that low phase after the cycle. Every selected word receives the same value.
- R2: A word whose `wen` bit is 0 in a cycle keeps its previous contents through that cycle.
- R3: When `wen` is all zeros, neither the master gated clock nor any slave gated clock pulses in that cycle. Toggling `wdata` during such cycles changes no stored word.
- R4: The master gated clock is high during a high clock phase exactly when at least one slave gated clock is high in that phase.
- R5: A word written in a cycle reads back its new value on both read ports after the falling edge of that cycle.
- R6: `rdata_a` and `rdata_b` return, combinationally and independently, the word whose index equals the binary value of `raddr_a` and `raddr_b` respectively.
- R7: While `rst` is 1, all gating latches are cleared, so no gated clock pulses and no word changes whatever `wen` and `wdata` are.
- R8: `wen` is captured only while `clk` is low. A change of `wen` during the high phase has no effect on the cycle in progress.
- R9: While a word's slave clock is high, its slave latches are transparent and the word equals the master latch output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage acts on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the gating latches |
| wen | input | R | Multi-hot write select, bit i selects word i |
| wdata | input | W | Write data bus |
| raddr_a | input | AW | Read address of port A |
| raddr_b | input | AW | Read address of port B |
| rdata_a | output | W | Word selected by raddr_a |
| rdata_b | output | W | Word selected by raddr_b |

## Verification
The bench applies random data with random multi-hot enables, including the all-zero vector, and compares every word through both read ports against an ordinary array of registers. A shared master that stayed transparent would corrupt all selected words. A gate that ignored a low enable bit would overwrite words that should be kept.

Directed cases toggle `wdata` during idle cycles, raise `wen` in the high phase, and hold `wen` all ones while `rst` is 1. A gating latch that was open in the wrong phase, or not cleared by reset, would let these stray values into storage. Reading straight after the write cycle catches a slave that captured on the wrong edge.

// File: rtl/srf_pkg.sv
package srf_pkg;
  // address width for a word count, never below one bit
  function automatic int unsigned addr_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/srf_latch.sv
// W-bit level-sensitive latch, transparent while gn is low
module srf_latch #(
  parameter int W = 16
) (
  input  logic         gn,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (!gn) q <= d;
  end
endmodule

// File: rtl/srf_clk_gate.sv
// latch-based clock gate: enable latch closed while clk high, then one AND gate
module srf_clk_gate (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic gclk
);
  logic en_q;

  always_latch begin
    if (!clk) en_q <= en & ~rst;
  end

  assign gclk = clk & en_q;
endmodule

// File: rtl/srf_read_port.sv
// combinational word select
module srf_read_port #(
  parameter int W  = 16,
  parameter int R  = 8,
  parameter int AW = 3
) (
  input  logic [R-1:0][W-1:0] words,
  input  logic [AW-1:0]       addr,
  output logic [W-1:0]        data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < R; i++) begin
      if (addr == AW'(i)) data = words[i];
    end
  end
endmodule

// File: rtl/srf_latch_regfile.sv
module srf_latch_regfile #(
  parameter  int W  = 16,
  parameter  int R  = 8,
  localparam int AW = srf_pkg::addr_bits(R)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [R-1:0]  wen,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  // named internal events for the checker
  logic               wr_any;
  logic               mclk;
  logic [R-1:0]       sclk;
  logic [W-1:0]       m_q;
  logic [R-1:0][W-1:0] store;

  assign wr_any = |wen;

  // master clock gate, enabled by the OR of all word enables
  srf_clk_gate u_mgate (
    .clk  (clk),
    .rst  (rst),
    .en   (wr_any),
    .gclk (mclk)
  );

  // one master latch for the whole bus, transparent while mclk low
  srf_latch #(.W(W)) u_master (
    .gn (mclk),
    .d  (wdata),
    .q  (m_q)
  );

  for (genvar i = 0; i < R; i++) begin : g_word
    logic sclk_n;

    srf_clk_gate u_sgate (
      .clk  (clk),
      .rst  (rst),
      .en   (wen[i]),
      .gclk (sclk[i])
    );

    assign sclk_n = ~sclk[i];

    // slave latch, transparent while its gated clock is high
    srf_latch #(.W(W)) u_slave (
      .gn (sclk_n),
      .d  (m_q),
      .q  (store[i])
    );
  end

  srf_read_port #(.W(W), .R(R), .AW(AW)) u_rd_a (
    .words (store),
    .addr  (raddr_a),
    .data  (rdata_a)
  );

  srf_read_port #(.W(W), .R(R), .AW(AW)) u_rd_b (
    .words (store),
    .addr  (raddr_b),
    .data  (rdata_b)
  );
endmodule

// File: rtl/srf_latch_regfile_chk.sv
module srf_latch_regfile_chk #(
  parameter int W = 16,
  parameter int R = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [R-1:0]        wen,
  input logic [W-1:0]        wdata,
  input logic                mclk,
  input logic [R-1:0]        sclk,
  input logic [W-1:0]        m_q,
  input logic [R-1:0][W-1:0] store
);
  // R4
  master_tracks_slaves_chk: assert property (@(negedge clk) disable iff (rst)
    mclk == (sclk != '0));

  // R3
  idle_no_clock_chk: assert property (@(negedge clk) disable iff (rst)
    (wen == '0) |-> (!mclk && sclk == '0));

  for (genvar i = 0; i < R; i++) begin : g_word_chk
    // R1
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
      wen[i] |=> (store[i] == $past(wdata)));

    // R2
    unselected_holds_chk: assert property (@(posedge clk) disable iff (rst)
      !wen[i] |=> (store[i] === $past(store[i])));

    // R9
    slave_follows_master_chk: assert property (@(negedge clk) disable iff (rst)
      sclk[i] |-> (store[i] == m_q));
  end
endmodule

bind srf_latch_regfile srf_latch_regfile_chk #(.W(W), .R(R)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wen   (wen),
  .wdata (wdata),
  .mclk  (mclk),
  .sclk  (sclk),
  .m_q   (m_q),
  .store (store)
);

// File: tb/srf_latch_regfile_tb.sv
`timescale 1ns/1ps
module srf_latch_regfile_tb;
  localparam int W  = 16;
  localparam int R  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [R-1:0]  wen = '0;
  logic [W-1:0]  wdata = '0;
  logic [AW-1:0] raddr_a = '0;
  logic [AW-1:0] raddr_b = '0;
  logic [W-1:0]  rdata_a, rdata_b;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] ref_mem [R];

  always #2.5 clk = ~clk; // 200 MHz

  srf_latch_regfile #(.W(W), .R(R)) u_dut (
    .clk(clk), .rst(rst), .wen(wen), .wdata(wdata),
    .raddr_a(raddr_a), .raddr_b(raddr_b),
    .rdata_a(rdata_a), .rdata_b(rdata_b)
  );

  // expected contents after a write: selected words take the data
  function automatic logic [W-1:0] next_word(input logic [W-1:0] old,
                                             input logic sel,
                                             input logic [W-1:0] d);
    return sel ? d : old;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive in the low phase, hold one cycle, then clear enables
  task automatic do_write(input logic [R-1:0] en, input logic [W-1:0] d);
    @(negedge clk); #1;
    wen = en; wdata = d;
    @(negedge clk); #1;
    wen = '0;
    for (int i = 0; i < R; i++) ref_mem[i] = next_word(ref_mem[i], en[i], d);
  endtask

  // read every word via both ports, port B walking in reverse
  task automatic read_all(input string tag);
    for (int i = 0; i < R; i++) begin
      raddr_a = AW'(i);
      raddr_b = AW'(R - 1 - i);
      #0.2;
      check(tag, rdata_a, ref_mem[i]);
      check(tag, rdata_b, ref_mem[R-1-i]);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;

    // R1: fill all words at once with one value
    do_write('1, 16'hA5C3);
    read_all("R1 broadcast");
    // R1/R5: distinct value into each word, read right after write cycle
    for (int i = 0; i < R; i++) begin
      do_write(R'(1) << i, W'(16'h1000 + i * 16'h0111));
      raddr_a = AW'(i); raddr_b = AW'(i); #0.2;
      check("R5 port A after fall", rdata_a, ref_mem[i]);
      check("R5 port B after fall", rdata_b, ref_mem[i]);
    end
    read_all("R6 per-word");

    // R3: idle cycles while the bus toggles
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      wen = '0; wdata = W'($urandom());
      @(posedge clk); #1;
      wdata = W'($urandom());
    end
    @(negedge clk); #1;
    read_all("R3 idle bus toggle");

    // R8: enable raised only during the high phase
    @(negedge clk); #1;
    wen = '0; wdata = 16'hDEAD;
    @(posedge clk); #1;
    wen = '1;
    @(negedge clk); #0.5;
    wen = '0;
    #0.5;
    read_all("R8 late enable");

    // R7: reset held while all enables are on
    @(negedge clk); #1;
    rst = 1'b1; wen = '1; wdata = 16'hBEEF;
    repeat (3) @(negedge clk);
    #1 wen = '0;
    read_all("R7 during reset");
    @(negedge clk); #1 rst = 1'b0;
    read_all("R7 after reset");

    // R1/R2/R6: random multi-hot writes, all-zero vectors included
    for (int n = 0; n < 150; n++) begin
      logic [R-1:0] en;
      en = R'($urandom());
      if (n % 7 == 0) en = '0;
      do_write(en, W'($urandom()));
      read_all("R2 random multi-hot");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule